// File: doc/BRIEF.md
# Triggered Timebase Capture Controller

This block fills a 256-entry waveform buffer with 8-bit converter samples. A prescaler makes a sample tick whose period is one of twelve power-of-two multiples of five system clocks. A sweep of 256 samples starts on a selected edge of a raw comparator input, or on a tick when free running. The sweep ends by itself once the last buffer entry has been written. A display engine reads the same buffer. It signals its read phase on `disp_phase`, and the block only writes while that phase is low, so reads and writes never meet.

Three run modes exist. In auto mode the block arms on trigger edges, and it falls back to arming on ticks once no edge has been seen for a timeout window. In free-run mode it arms on every idle tick and ignores the trigger. In hold mode the prescaler is held clear and the sweep sequencer is frozen, so the stored trace stays as it is.

The sequencer has three states. `ST_IDLE` is disarmed, with the address held at zero. `ST_WAIT_TICK` is armed and waiting for the next sample tick. `ST_WAIT_SLOT` holds a latched sample until a write slot comes. The transitions are:
- `ST_IDLE` to `ST_WAIT_TICK` on a start event.
- `ST_WAIT_TICK` to `ST_WAIT_SLOT` on a tick.
- `ST_WAIT_SLOT` to `ST_WAIT_TICK` on a write below the last address.
- `ST_WAIT_SLOT` to `ST_IDLE` on the write to the last address.

All transitions are suspended in hold mode.

Top module: `capt_sweep_ctrl`

## Requirements
- R1: After reset, `sweep_active` is 0, `wr_en` is 0, `wr_addr` is 0 and `wr_data` is 0.
- R2: The sample tick period is 5·2^k system clocks, where k = `tb_sel` for values 0..11. Values 12..15 act as 11. The ticks run on a prescaler that counts from reset.
- R3: `trig_raw` passes through two synchronizing flops before edge detection. `trig_fall`=0 selects rising edges and `trig_fall`=1 selects falling edges. An edge of the selected kind arms the sweep in auto mode, and `sweep_active` rises at the third clock edge after the input changes. An edge of the other kind does nothing.
- R4: While disarmed, `wr_addr` is 0 and `wr_en` stays 0. Arming does not capture a sample. The first sample is taken on the first tick after arming.
- R5: While armed, each tick latches `adc_data`. The write strobe is asserted in the first cycle that has `disp_phase` low, and `wr_addr` advances by one after each write.
- R6: The write to address 255 ends the sweep. `sweep_active` falls and `wr_addr` returns to 0, and a new start event is needed to arm again. Each sweep makes exactly 256 writes at addresses 0..255, in order.
- R7: Trigger edges that arrive while a sweep is active have no effect on it.
- R8: In auto mode (`mode_sel`=0), a timeout counter is reloaded with TO_CYCLES on each selected edge and counts down otherwise. Once it reaches zero, a sample tick acts as the start event.
- R9: In free-run mode (`mode_sel`=1), every tick seen while disarmed is a start event, and the trigger input is ignored.
- R10: In hold mode (`mode_sel`=2 or 3), the prescaler is held clear, no write happens, and `wr_addr` and `sweep_active` keep their values. After release, the next tick comes 5·2^k clocks later.
- R11: A tick that arrives while a latched sample is still waiting for its write slot is dropped.
- R12: `wr_data` is the `adc_data` value present on the tick that captured it, and it stays stable until that sample has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 8 | Converter sample bus |
| trig_raw | input | 1 | Raw comparator trigger, asynchronous |
| trig_fall | input | 1 | Edge select: 0 rising, 1 falling |
| mode_sel | input | 2 | 0 auto, 1 free-run, 2 or 3 hold |
| tb_sel | input | 4 | Timebase select, 0..11 (larger values clamp to 11) |
| disp_phase | input | 1 | High while the display owns the buffer |
| wr_addr | output | 8 | Buffer write address (current sweep position) |
| wr_data | output | 8 | Buffer write data |
| wr_en | output | 1 | Buffer write strobe |
| sweep_active | output | 1 | Sweep armed (start seen, sweep not yet complete) |

## Verification
Some rules are checked by the assertions on every cycle:
- writes never coincide with the display phase or with hold mode;
- the address stays at zero while disarmed;
- each write steps the address by one, and the write to the last entry disarms the sweep;
- hold mode leaves the address and the armed flag untouched.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared on every clock:
- the exact tick spacing at each timebase, including the clamp;
- the three-clock trigger latency and the polarity choice;
- the auto timeout fallback;
- the dropping of ticks while a write is pending;
- the sample values that land in the buffer.

// File: rtl/capt_pkg.sv
package capt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_TICK = 2'd1,
        ST_WAIT_SLOT = 2'd2
    } sweep_state_t;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'd0,
        MODE_FREE  = 2'd1,
        MODE_HOLD  = 2'd2,
        MODE_HOLD2 = 2'd3
    } run_mode_t;

endpackage

// File: rtl/capt_prescale.sv
module capt_prescale #(
    parameter int PRE_DIV   = 5,
    parameter int NUM_RATES = 12,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int DIV_W = $clog2(PRE_DIV);
    localparam int BIN_W = NUM_RATES - 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRE_DIV - 1);
    localparam logic [SEL_W-1:0] SEL_MAX  = SEL_W'(NUM_RATES - 1);
    localparam logic [BIN_W:0]   ONE      = (BIN_W + 1)'(1);

    logic [DIV_W-1:0] div_q;
    logic [BIN_W-1:0] bin_q;
    logic [SEL_W-1:0] eff_sel;
    logic [BIN_W:0]   span;
    logic [BIN_W-1:0] mask;
    logic             div_wrap;

    // Clamp the selector, then build a mask of the binary stages in use.
    always_comb begin
        eff_sel = (rate_sel > SEL_MAX) ? SEL_MAX : rate_sel;
        span    = (ONE << eff_sel) - ONE;
        mask    = span[BIN_W-1:0];
    end

    assign div_wrap = (div_q == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            bin_q <= '0;
        end else if (hold) begin
            div_q <= '0;
            bin_q <= '0;
        end else if (div_wrap) begin
            div_q <= '0;
            bin_q <= bin_q + BIN_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = !hold && div_wrap && ((bin_q & mask) == mask);

endmodule

// File: rtl/capt_trig.sv
module capt_trig #(
    parameter int SYNC_STAGES = 2,
    parameter int TO_CYCLES   = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_raw,
    input  logic trig_fall,
    output logic trig_edge,
    output logic quiet
);
    localparam int TO_W = $clog2(TO_CYCLES + 1);
    localparam logic [TO_W-1:0] TO_LOAD = TO_W'(TO_CYCLES);

    // Synchronizer stages plus one history flop for edge detection.
    logic [SYNC_STAGES:0] chain_q;
    logic [TO_W-1:0]      quiet_cnt_q;
    logic                 lvl_now;
    logic                 lvl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], trig_raw};
    end

    assign lvl_now   = chain_q[SYNC_STAGES-1];
    assign lvl_prev  = chain_q[SYNC_STAGES];
    assign trig_edge = trig_fall ? (lvl_prev & ~lvl_now) : (lvl_now & ~lvl_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  quiet_cnt_q <= TO_LOAD;
        else if (trig_edge)          quiet_cnt_q <= TO_LOAD;
        else if (quiet_cnt_q != '0)  quiet_cnt_q <= quiet_cnt_q - TO_W'(1);
    end

    assign quiet = (quiet_cnt_q == '0);

endmodule

// File: rtl/capt_seq.sv
module capt_seq
    import capt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tick,
    input  logic              start,
    input  logic              disp_phase,
    input  logic [DATA_W-1:0] sample_in,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              sweep_active
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    sweep_state_t      state_q;
    sweep_state_t      state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] smp_q;

    // Next-state logic; hold freezes every transition.
    always_comb begin
        state_d = state_q;
        if (!hold) begin
            unique case (state_q)
                ST_IDLE:      if (start)       state_d = ST_WAIT_TICK;
                ST_WAIT_TICK: if (tick)        state_d = ST_WAIT_SLOT;
                ST_WAIT_SLOT: if (!disp_phase) state_d = (addr_q == ADDR_LAST) ? ST_IDLE : ST_WAIT_TICK;
                default:                       state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state register.
    always_comb begin
        wr_en        = (state_q == ST_WAIT_SLOT) && !disp_phase && !hold;
        sweep_active = (state_q != ST_IDLE);
        wr_addr      = addr_q;
        wr_data      = smp_q;
    end

    // Datapath: sample latch and sweep address (wraps to zero after the last write).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            smp_q  <= '0;
        end else begin
            if (state_q == ST_WAIT_TICK && tick) smp_q <= sample_in;
            if (wr_en) addr_q <= addr_q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/capt_sweep_ctrl.sv
module capt_sweep_ctrl
    import capt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int PRE_DIV   = 5,
    parameter int NUM_RATES = 12,
    parameter int SEL_W     = 4,
    parameter int TO_CYCLES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              trig_raw,
    input  logic              trig_fall,
    input  logic [1:0]        mode_sel,
    input  logic [SEL_W-1:0]  tb_sel,
    input  logic              disp_phase,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              sweep_active
);
    run_mode_t mode;
    logic      hold;
    logic      tick;
    logic      trig_edge;
    logic      quiet;
    logic      start;

    assign mode = run_mode_t'(mode_sel);
    assign hold = (mode == MODE_HOLD) || (mode == MODE_HOLD2);

    capt_prescale #(
        .PRE_DIV  (PRE_DIV),
        .NUM_RATES(NUM_RATES),
        .SEL_W    (SEL_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .rate_sel(tb_sel),
        .tick    (tick)
    );

    capt_trig #(
        .SYNC_STAGES(2),
        .TO_CYCLES  (TO_CYCLES)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_raw (trig_raw),
        .trig_fall(trig_fall),
        .trig_edge(trig_edge),
        .quiet    (quiet)
    );

    // Start-event selection per run mode.
    always_comb begin
        unique case (mode)
            MODE_AUTO: start = trig_edge | (quiet & tick);
            MODE_FREE: start = tick;
            default:   start = 1'b0;
        endcase
    end

    capt_seq #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .tick        (tick),
        .start       (start),
        .disp_phase  (disp_phase),
        .sample_in   (adc_data),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_en       (wr_en),
        .sweep_active(sweep_active)
    );

endmodule

// File: rtl/capt_sweep_chk.sv
module capt_sweep_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              disp_phase,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_en,
    input logic              sweep_active
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_active |-> wr_addr == '0);                                      // R4
    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sweep_active);                                               // R4
    AST_WRITE_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !disp_phase);                                                // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != LAST) |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1)); // R5
    AST_ONE_WRITE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                                     // R5
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LAST) |=> !sweep_active);                         // R6
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel[1] |-> !wr_en);                                               // R10
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel[1] |=> $stable(wr_addr) && $stable(sweep_active));            // R10

endmodule

bind capt_sweep_ctrl capt_sweep_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .disp_phase  (disp_phase),
    .wr_addr     (wr_addr),
    .wr_en       (wr_en),
    .sweep_active(sweep_active)
);

// File: tb/capt_sweep_ctrl_test.sv
`timescale 1ns/1ps
module capt_sweep_ctrl_test;
    localparam int TO = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic       trig_raw = 1'b0;
    logic       trig_fall = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [3:0] tb_sel = 4'd0;
    logic       disp_phase = 1'b0;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_en;
    logic       sweep_active;

    int n_cmp = 0;
    int n_bad = 0;
    int phase_mode = 0;   // 0 toggle, 1 stuck high, 2 stuck low
    string cur_req = "R1";

    capt_sweep_ctrl #(.TO_CYCLES(TO)) uut (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .trig_raw(trig_raw),
        .trig_fall(trig_fall), .mode_sel(mode_sel), .tb_sel(tb_sel),
        .disp_phase(disp_phase), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_en(wr_en), .sweep_active(sweep_active)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Background drivers for the display phase and the converter data.
    initial begin
        forever begin
            @(posedge clk); #2;
            case (phase_mode)
                0: disp_phase = ~disp_phase;
                1: disp_phase = 1'b1;
                default: disp_phase = 1'b0;
            endcase
            adc_data = adc_data * 8'd5 + 8'd3;
        end
    end

    // Behavioural reference model.
    int m_pc, m_to, m_st, m_addr, m_smp, cyc;
    bit rawq[$];
    always @(posedge clk) begin
        bit hold, tick, edge_ev, start;
        int per;
        cyc++;
        if (!rst_n) begin
            m_pc = 0; m_to = TO; m_st = 0; m_addr = 0; m_smp = 0;
            rawq = '{1'b0, 1'b0, 1'b0};
        end else begin
            hold    = (mode_sel >= 2);
            per     = 5 << ((tb_sel > 11) ? 11 : tb_sel);
            tick    = !hold && (((m_pc + 1) % per) == 0);
            edge_ev = trig_fall ? (rawq[2] && !rawq[1]) : (rawq[1] && !rawq[2]);
            start   = (mode_sel == 0) ? (edge_ev || (m_to == 0 && tick))
                    : (mode_sel == 1) ? tick : 1'b0;
            if (!hold) begin
                if (m_st == 0) begin
                    if (start) m_st = 1;
                end else if (m_st == 1) begin
                    if (tick) begin m_smp = adc_data; m_st = 2; end
                end else if (!disp_phase) begin
                    if (m_addr == 255) begin m_addr = 0; m_st = 0; end
                    else begin m_addr++; m_st = 1; end
                end
            end
            if (edge_ev) m_to = TO; else if (m_to > 0) m_to--;
            m_pc = hold ? 0 : (m_pc + 1) % 10240;
            rawq.push_front(trig_raw);
            void'(rawq.pop_back());
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, wr_en, (m_st == 2 && mode_sel < 2 && !disp_phase) ? 1 : 0);
            chk(cur_req, sweep_active, (m_st != 0) ? 1 : 0);
            chk(cur_req, wr_addr, m_addr);
            chk("R12", wr_data, m_smp);
        end
    end

    // Write monitor for directed checks.
    int mon_writes, mon_next, mon_order_bad, wr_last, wr_prev;
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_writes = 0; mon_next = 0; mon_order_bad = 0; wr_last = 0; wr_prev = 0;
        end else if (wr_en) begin
            if (wr_addr != mon_next) mon_order_bad++;
            mon_next = (wr_addr + 1) % 256;
            mon_writes++;
            wr_prev = wr_last;
            wr_last = cyc;
        end
    end

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!sweep_active) break;
        end
    endtask

    task automatic trig_latency(input bit level, input string req);
        @(posedge clk); #2 trig_raw = level;
        repeat (2) @(posedge clk);
        @(negedge clk); chk(req, sweep_active, 0);
        @(negedge clk); chk(req, sweep_active, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        #1 chk("R1", wr_en, 0); chk("R1", sweep_active, 0); chk("R1", wr_addr, 0); chk("R1", wr_data, 0);
        do_reset();
        @(negedge clk);
        chk("R1", wr_en, 0); chk("R1", sweep_active, 0); chk("R1", wr_addr, 0);

        // R4: idle with no start event stays at address zero
        cur_req = "R4";
        repeat (100) @(negedge clk);
        chk("R4", mon_writes, 0); chk("R4", wr_addr, 0);

        // R3 rising edge, then R7 triggers during the sweep, R5/R6 full sweep
        cur_req = "R3";
        trig_latency(1'b1, "R3");
        cur_req = "R7";
        for (int k = 0; k < 6; k++) begin
            repeat (50) @(posedge clk); #2 trig_raw = ~trig_raw;
        end
        cur_req = "R5";
        wait_idle(5000);
        chk("R6", mon_writes, 256); chk("R5", mon_order_bad, 0); chk("R6", wr_addr, 0);
        chk("R7", mon_writes, 256);

        // R3 falling polarity; then R10 hold mid-sweep
        do_reset();
        cur_req = "R3";
        trig_fall = 1'b1;
        @(posedge clk); #2 trig_raw = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3", sweep_active, 0);
        trig_latency(1'b0, "R3");
        repeat (60) @(negedge clk);
        cur_req = "R10";
        @(posedge clk); #2 mode_sel = 2'd2;
        @(negedge clk);
        begin
            int w0, a0;
            w0 = mon_writes; a0 = wr_addr;
            repeat (300) @(negedge clk);
            chk("R10", mon_writes, w0); chk("R10", wr_addr, a0); chk("R10", sweep_active, 1);
        end
        @(posedge clk); #2 mode_sel = 2'd3;
        repeat (20) @(negedge clk);
        @(posedge clk); #2 mode_sel = 2'd0;
        wait_idle(5000);
        chk("R6", mon_writes, 256);
        trig_fall = 1'b0; trig_raw = 1'b0;

        // R8 auto timeout fallback
        do_reset();
        cur_req = "R8";
        repeat (395) @(negedge clk);
        chk("R8", sweep_active, 0);
        repeat (25) @(negedge clk);
        chk("R8", sweep_active, 1);
        wait_idle(5000);
        chk("R8", mon_writes, 256);

        // R9 free-run ignores the trigger
        do_reset();
        cur_req = "R9";
        mode_sel = 2'd1;
        repeat (8) @(negedge clk);
        chk("R9", sweep_active, 1);
        for (int k = 0; k < 8; k++) begin
            repeat (37) @(posedge clk); #2 trig_raw = ~trig_raw;
        end
        wait_idle(5000);
        chk("R9", mon_writes, 256); chk("R9", mon_order_bad, 0);

        // R11 pending write blocks later ticks
        do_reset();
        cur_req = "R11";
        phase_mode = 1;
        repeat (30) @(negedge clk);
        chk("R11", mon_writes, 0); chk("R11", sweep_active, 1);
        phase_mode = 0;
        wait_idle(5000);
        chk("R11", mon_writes, 256);

        // R2 tick spacing at timebase 3 and clamped 15
        do_reset();
        cur_req = "R2";
        phase_mode = 2; tb_sel = 4'd3;
        while (mon_writes < 2) @(negedge clk);
        chk("R2", wr_last - wr_prev, 40);
        do_reset();
        tb_sel = 4'd15;
        while (mon_writes < 2) @(negedge clk);
        chk("R2", wr_last - wr_prev, 10240);

        summary();
        $finish;
    end
endmodule